// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes a set of external interrupt request lines to processors as delivery messages. Each line has a redirection entry of two 32-bit words. The entry sets the message vector, the destination identifier and the destination mode. It also sets whether the line is masked, edge or level triggered, and active high or active low. Each line passes through a two-flop synchroniser and then through polarity correction. After that, an edge detector or a level qualifier turns it into a request.

Software reaches the controller with an index-then-data scheme. A write to the index register picks an internal register. Reads and writes of the data window then act on that register. The internal registers are an identifier register, a version register and the redirection entries.

Delivery messages leave on a valid/ready handshake, and the lowest-numbered requesting input is served first. A level-triggered input cannot deliver again after a delivery until it is released. It is released by an end-of-interrupt notice that carries a matching vector.

Top module: `irq_redirect`

## Requirements
- R1: The index register sits at byte offset 0x00: it keeps bits 7:0 of a write and reads back zero-extended. The data window at offset 0x10 acts on the register that the last index write selected. Every other offset reads zero. Read data appears on `bus_rdata` on the clock edge that samples `bus_rd` and holds until the next read.
- R2: Index 0x00 reads CTRL_ID in bits 31:24 and zero elsewhere. Index 0x01 reads NUM_IRQ-1 in bits 23:16, 0x11 in bits 7:0, and zero elsewhere. Writes to both registers have no effect.
- R3: Input n has its low word at index 0x10+2n and its high word at index 0x10+2n+1. The low word holds: bit 16 mask, bit 15 level mode (clear means edge), bit 13 active low, bit 11 logical destination, and bits 7:0 vector. The high word holds the destination in bits 31:24. All other bits read zero whatever is written.
- R4: After reset every low word reads 0x00010000 and every high word reads zero. Indices above the last entry, and indices 0x02 to 0x0F, read zero and ignore writes.
- R5: Consider an input first sampled active at clock edge k. In edge mode, `msg_valid` is first high after edge k+3. In level mode, it is first high after edge k+2.
- R6: In edge mode, each inactive-to-active transition of an unmasked input yields exactly one message, however long the line stays active. A transition that occurs while the entry is masked is never delivered. Setting the mask discards a pending edge.
- R7: In level mode, an unmasked active input delivers one message, and that delivery sets a remote flag for the entry. While the flag is set, no further message comes from the entry. An `eoi_valid` pulse whose `eoi_vector` equals the entry's vector clears the flag.
- R8: With the active-low bit set, a low line level counts as active and a high level counts as inactive.
- R9: A message carries the entry's vector, destination, logical bit and level bit. It holds stable while `msg_valid` is high and `msg_ready` is low. After a handshake, `msg_valid` is low for at least one cycle.
- R10: When several inputs request at the same time, the lowest-numbered input is delivered first.
- R11: A masked entry never starts a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset: 0x00 index, 0x10 data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt notice |
| irq_in | input | NUM_IRQ | Asynchronous interrupt request lines |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination identifier |
| msg_logical | output | 1 | Destination is logical (1) or physical (0) |
| msg_level | output | 1 | Message came from a level-triggered entry |

## Verification
The bench builds the controller with NUM_IRQ=4 and CTRL_ID=0x3C. With four inputs, the last entry (index 0x17) and the first undefined index above the table (0x18) are only a few register writes away. The version field reads 3, which a miscounted depth would not produce. The non-default identifier shows that bits 31:24 come from the parameter. Four inputs also allow a three-way tie for priority, plus one active-low line that stays apart from it.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  typedef struct packed {
    logic       masked;
    logic       level;
    logic       act_low;
    logic       logical;
    logic [7:0] vector;
    logic [7:0] dest;
  } redir_entry_t;

  localparam logic [7:0] IDX_ID    = 8'h00;
  localparam logic [7:0] IDX_VER   = 8'h01;
  localparam logic [7:0] IDX_TABLE = 8'h10;
  localparam logic [7:0] VER_CODE  = 8'h11;

  function automatic logic [31:0] pack_low(input redir_entry_t e);
    return {15'b0, e.masked, e.level, 1'b0, e.act_low, 1'b0, e.logical, 3'b0, e.vector};
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] line,
  input  logic [NUM_IRQ-1:0] masked,
  input  logic [NUM_IRQ-1:0] level,
  input  logic [NUM_IRQ-1:0] act_low,
  input  logic [NUM_IRQ-1:0] grant,
  input  logic [NUM_IRQ-1:0] eoi_hit,
  output logic [NUM_IRQ-1:0] req,
  output logic [NUM_IRQ-1:0] remote
);
  logic [NUM_IRQ-1:0] active, prev, pend;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_in
    logic rise;
    assign active[i] = line[i] ^ act_low[i];
    assign rise      = active[i] & ~prev[i];
    assign req[i]    = ~masked[i] & (level[i] ? (active[i] & ~remote[i]) : pend[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev[i]   <= 1'b0;
        pend[i]   <= 1'b0;
        remote[i] <= 1'b0;
      end else begin
        prev[i] <= active[i];
        if (masked[i] || level[i]) pend[i] <= 1'b0;
        else if (rise)             pend[i] <= 1'b1;
        else if (grant[i])         pend[i] <= 1'b0;
        if (grant[i] && level[i])  remote[i] <= 1'b1;
        else if (eoi_hit[i])       remote[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
  import irq_redir_pkg::*;
#(
  parameter int          NUM_IRQ = 8,
  parameter logic [7:0]  CTRL_ID = 8'h01,
  parameter int          ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               eoi_valid,
  input  logic [7:0]         eoi_vector,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [7:0]         msg_vector,
  output logic [7:0]         msg_dest,
  output logic               msg_logical,
  output logic               msg_level
);
  localparam int SRC_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ADDR_W-1:0] OFS_INDEX = '0;
  localparam logic [ADDR_W-1:0] OFS_WIN   = ADDR_W'(16);
  localparam logic [8:0] TABLE_END = 9'(16 + 2 * NUM_IRQ);

  logic [7:0]         reg_index;
  redir_entry_t       tbl [NUM_IRQ];
  logic [NUM_IRQ-1:0] mask_vec, level_vec, low_vec, eoi_hit, req_vec, remote_vec, grant_vec, line_s;
  logic [SRC_W-1:0]   msg_src, sel;
  logic               any_req, win_wr, ent_hit;
  logic [7:0]         rel;
  logic [6:0]         ent_no;
  logic [31:0]        ent_low, ent_high, rd_val;

  // index register and window decode
  assign win_wr  = bus_wr && (bus_addr == OFS_WIN);
  assign ent_hit = (reg_index >= IDX_TABLE) && ({1'b0, reg_index} < TABLE_END);
  assign rel     = reg_index - IDX_TABLE;
  assign ent_no  = rel[7:1];

  always_ff @(posedge clk) begin
    if (rst)                                   reg_index <= '0;
    else if (bus_wr && bus_addr == OFS_INDEX)  reg_index <= bus_wdata[7:0];
  end

  // redirection table, one pair of words per input
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ent
    logic hit;
    assign hit = win_wr && ent_hit && (ent_no == 7'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[i] <= '{masked: 1'b1, default: '0};
      end else if (hit && !rel[0]) begin
        tbl[i].masked  <= bus_wdata[16];
        tbl[i].level   <= bus_wdata[15];
        tbl[i].act_low <= bus_wdata[13];
        tbl[i].logical <= bus_wdata[11];
        tbl[i].vector  <= bus_wdata[7:0];
      end else if (hit) begin
        tbl[i].dest    <= bus_wdata[31:24];
      end
    end

    assign mask_vec[i]  = tbl[i].masked;
    assign level_vec[i] = tbl[i].level;
    assign low_vec[i]   = tbl[i].act_low;
    assign eoi_hit[i]   = eoi_valid && (tbl[i].vector == eoi_vector);
  end

  // read path
  always_comb begin
    ent_low  = '0;
    ent_high = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (ent_no == 7'(i)) begin
        ent_low  = pack_low(tbl[i]);
        ent_high = {tbl[i].dest, 24'h0};
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == OFS_INDEX) begin
      rd_val = {24'h0, reg_index};
    end else if (bus_addr == OFS_WIN) begin
      if (reg_index == IDX_ID)       rd_val = {CTRL_ID, 24'h0};
      else if (reg_index == IDX_VER) rd_val = {8'h0, 8'(NUM_IRQ - 1), 8'h0, VER_CODE};
      else if (ent_hit)              rd_val = rel[0] ? ent_high : ent_low;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // input conditioning and request generation
  irq_sync #(.WIDTH(NUM_IRQ)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(line_s)
  );

  irq_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst(rst), .line(line_s), .masked(mask_vec), .level(level_vec),
    .act_low(low_vec), .grant(grant_vec), .eoi_hit(eoi_hit),
    .req(req_vec), .remote(remote_vec)
  );

  // fixed priority: lowest input wins
  always_comb begin
    sel     = '0;
    any_req = 1'b0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        sel     = SRC_W'(i);
        any_req = 1'b1;
      end
    end
    grant_vec = '0;
    if (!msg_valid && any_req) grant_vec[sel] = 1'b1;
  end

  // message register
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid   <= 1'b0;
      msg_vector  <= '0;
      msg_dest    <= '0;
      msg_logical <= 1'b0;
      msg_level   <= 1'b0;
      msg_src     <= '0;
    end else if (msg_valid) begin
      if (msg_ready) msg_valid <= 1'b0;
    end else if (any_req) begin
      msg_valid   <= 1'b1;
      msg_vector  <= tbl[sel].vector;
      msg_dest    <= tbl[sel].dest;
      msg_logical <= tbl[sel].logical;
      msg_level   <= tbl[sel].level;
      msg_src     <= sel;
    end
  end

  logic unused_ok;
  assign unused_ok = ^remote_vec;

endmodule

// File: rtl/irq_redirect_chk.sv
module irq_redirect_chk #(
  parameter int         NUM_IRQ = 8,
  parameter logic [7:0] CTRL_ID = 8'h01,
  parameter int         ADDR_W  = 5,
  parameter int         SRC_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_rdata,
  input logic [7:0]         reg_index,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [7:0]         msg_vector,
  input logic [7:0]         msg_dest,
  input logic               msg_logical,
  input logic               msg_level,
  input logic [SRC_W-1:0]   msg_src,
  input logic [NUM_IRQ-1:0] req_vec,
  input logic [NUM_IRQ-1:0] mask_vec
);
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(16);

  assert_msg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest)
                                && $stable(msg_logical) && $stable(msg_level));

  assert_gap_after_hs_R9: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready |=> !msg_valid);

  assert_masked_silent_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> (($past(mask_vec) & (NUM_IRQ'(1) << msg_src)) == '0));

  assert_low_first_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> (($past(req_vec) & ((NUM_IRQ'(1) << msg_src) - NUM_IRQ'(1))) == '0));

  assert_id_read_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == WIN && reg_index == 8'h00 |=> bus_rdata == {CTRL_ID, 24'h0});

  assert_bad_offset_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr != '0 && bus_addr != WIN |=> bus_rdata == 32'h0);
endmodule

bind irq_redirect irq_redirect_chk #(.NUM_IRQ(NUM_IRQ), .CTRL_ID(CTRL_ID), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_redirect_bench.sv
module irq_redirect_bench;
  localparam int         N   = 4;
  localparam logic [7:0] CID = 8'h3C;

  logic        clk = 0, rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eoi_valid = 0;
  logic [7:0]  eoi_vector = '0;
  logic [N-1:0] irq = '0;
  logic        msg_valid, msg_ready = 1;
  logic [7:0]  msg_vector, msg_dest;
  logic        msg_logical, msg_level;

  always #4 clk = ~clk;

  irq_redirect #(.NUM_IRQ(N), .CTRL_ID(CID), .ADDR_W(5)) u_irq_redirect (
    .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .eoi_valid, .eoi_vector, .irq_in(irq), .msg_valid, .msg_ready,
    .msg_vector, .msg_dest, .msg_logical, .msg_level
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_s1[N], m_s2[N], m_prev[N], m_pend[N], m_rem[N];
  bit m_mask[N], m_lvl[N], m_alow[N], m_log[N];
  bit [7:0] m_vec[N], m_dst[N];
  bit [7:0] m_index;
  bit [31:0] m_rdata;
  bit m_valid, m_olog, m_olvl;
  bit [7:0] m_ovec, m_odst;

  function automatic bit [31:0] mread(input bit [4:0] a, input bit [7:0] idx);
    int e;
    if (a == 5'h00) return {24'h0, idx};
    if (a != 5'h10) return 0;
    if (idx == 8'h00) return {CID, 24'h0};
    if (idx == 8'h01) return {8'h0, 8'(N - 1), 8'h0, 8'h11};
    if (idx < 8'h10 || idx >= 8'(16 + 2 * N)) return 0;
    e = (idx - 16) / 2;
    if (idx[0]) return {m_dst[e], 24'h0};
    return (m_mask[e] ? 32'h10000 : 0) | (m_lvl[e] ? 32'h8000 : 0) |
           (m_alow[e] ? 32'h2000 : 0) | (m_log[e] ? 32'h800 : 0) | 32'(m_vec[e]);
  endfunction

  always @(posedge clk) begin
    bit act[N];
    bit req[N];
    int g, e;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_pend[i] = 0; m_rem[i] = 0;
        m_mask[i] = 1; m_lvl[i] = 0; m_alow[i] = 0; m_log[i] = 0; m_vec[i] = 0; m_dst[i] = 0;
      end
      m_index = 0; m_rdata = 0; m_valid = 0; m_ovec = 0; m_odst = 0; m_olog = 0; m_olvl = 0;
    end else begin
      g = -1;
      for (int i = 0; i < N; i++) begin
        act[i] = m_s2[i] ^ m_alow[i];
        req[i] = !m_mask[i] && (m_lvl[i] ? (act[i] && !m_rem[i]) : m_pend[i]);
      end
      if (m_valid) begin
        if (msg_ready) m_valid = 0;
      end else begin
        for (int i = N - 1; i >= 0; i--) if (req[i]) g = i;
        if (g >= 0) begin
          m_valid = 1; m_ovec = m_vec[g]; m_odst = m_dst[g]; m_olog = m_log[g]; m_olvl = m_lvl[g];
        end
      end
      for (int i = 0; i < N; i++) begin
        if (m_mask[i] || m_lvl[i]) m_pend[i] = 0;
        else if (act[i] && !m_prev[i]) m_pend[i] = 1;
        else if (g == i) m_pend[i] = 0;
        if (g == i && m_lvl[i]) m_rem[i] = 1;
        else if (eoi_valid && m_vec[i] == eoi_vector) m_rem[i] = 0;
        m_prev[i] = act[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = irq[i];
      end
      if (bus_rd) m_rdata = mread(bus_addr, m_index);
      if (bus_wr && bus_addr == 5'h00) m_index = bus_wdata[7:0];
      else if (bus_wr && bus_addr == 5'h10 && m_index >= 8'h10 && m_index < 8'(16 + 2 * N)) begin
        e = (m_index - 16) / 2;
        if (m_index[0]) m_dst[e] = bus_wdata[31:24];
        else begin
          m_mask[e] = bus_wdata[16]; m_lvl[e] = bus_wdata[15];
          m_alow[e] = bus_wdata[13]; m_log[e] = bus_wdata[11]; m_vec[e] = bus_wdata[7:0];
        end
      end
    end
  end

  // per-cycle comparison and handshake log
  int hs_count = 0;
  logic [7:0] hs_vec[$];
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R9 msg_valid", 32'(msg_valid), 32'(m_valid));
      if (m_valid)
        check("R9 msg fields", {14'h0, msg_logical, msg_level, msg_dest, msg_vector},
                               {14'h0, m_olog, m_olvl, m_odst, m_ovec});
      check("R1 rdata", bus_rdata, m_rdata);
      if (msg_valid && msg_ready) begin
        hs_count++;
        hs_vec.push_back(msg_vector);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic wr_reg(input logic [7:0] idx, input logic [31:0] d);
    wr(5'h00, {24'h0, idx}); wr(5'h10, d);
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask
  task automatic rd_reg(input logic [7:0] idx, output logic [31:0] v);
    wr(5'h00, {24'h0, idx}); rd(5'h10, v);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1; eoi_vector = v;
    @(negedge clk); eoi_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base, lat;
    idle(3); @(negedge clk); rst = 0;

    // R4 reset state, R1/R2 register file
    rd_reg(8'h10, v); check("R4 reset low word", v, 32'h00010000);
    rd_reg(8'h17, v); check("R4 reset high word", v, 32'h0);
    rd(5'h00, v);     check("R1 index readback", v, 32'h17);
    rd(5'h04, v);     check("R1 unused offset", v, 32'h0);
    rd_reg(8'h00, v); check("R2 id", v, {CID, 24'h0});
    rd_reg(8'h01, v); check("R2 version", v, 32'h00030011);
    wr_reg(8'h00, 32'hFFFFFFFF); rd(5'h10, v); check("R2 id read-only", v, {CID, 24'h0});
    wr_reg(8'h18, 32'hFFFFFFFF); rd(5'h10, v); check("R4 undefined index", v, 32'h0);
    wr_reg(8'h05, 32'hFFFFFFFF); rd(5'h10, v); check("R4 gap index", v, 32'h0);
    wr_reg(8'h16, 32'hFFFFFFFF); rd(5'h10, v); check("R3 low word bits", v, 32'h0001A8FF);
    wr_reg(8'h17, 32'hFFFFFFFF); rd(5'h10, v); check("R3 high word bits", v, 32'hFF000000);
    wr_reg(8'h16, 32'h00010000); wr_reg(8'h17, 32'h0);

    // R11 / R6: edge while masked is lost
    base = hs_count;
    @(negedge clk); irq[0] = 1; idle(6); irq[0] = 0; idle(4);
    wr_reg(8'h11, 32'h02000000); wr_reg(8'h10, 32'h00000040);
    idle(10); check("R11 masked edge not delivered", 32'(hs_count - base), 0);

    // R6 edge: one message per transition
    base = hs_count;
    @(negedge clk); irq[0] = 1; idle(20);
    check("R6 one message per edge", 32'(hs_count - base), 1);
    irq[0] = 0; idle(5); irq[0] = 1; idle(10); irq[0] = 0; idle(4);
    check("R6 second edge", 32'(hs_count - base), 2);

    // R5 latency edge, logical destination on entry 1
    wr_reg(8'h13, 32'h09000000); wr_reg(8'h12, 32'h00000841);
    idle(3);
    @(negedge clk); irq[1] = 1; lat = 0;
    while (!msg_valid && lat < 20) begin @(negedge clk); lat++; end
    check("R5 edge latency", 32'(lat), 4);
    check("R9 logical bit", 32'(msg_logical), 1);
    idle(3); irq[1] = 0;

    // R7 level, R5 level latency
    wr_reg(8'h15, 32'h05000000); wr_reg(8'h14, 32'h00008052);
    idle(3); base = hs_count;
    @(negedge clk); irq[2] = 1; lat = 0;
    while (!msg_valid && lat < 20) begin @(negedge clk); lat++; end
    check("R5 level latency", 32'(lat), 3);
    idle(20); check("R7 remote blocks repeat", 32'(hs_count - base), 1);
    eoi(8'h99); idle(6); check("R7 other vector ignored", 32'(hs_count - base), 1);
    eoi(8'h52); idle(6); check("R7 eoi releases", 32'(hs_count - base), 2);
    irq[2] = 0; idle(3); eoi(8'h52); idle(8);
    check("R7 released idle line silent", 32'(hs_count - base), 2);

    // R8 polarity on entry 3
    irq[3] = 1; idle(4);
    wr_reg(8'h17, 32'h07000000); wr_reg(8'h16, 32'h00002063);
    idle(6); base = hs_count;
    @(negedge clk); irq[3] = 0; idle(10);
    check("R8 low level is active", 32'(hs_count - base), 1);
    irq[3] = 1; idle(10);
    check("R8 high level inactive", 32'(hs_count - base), 1);

    // R10 priority with ready held low, R9 hold
    wr_reg(8'h14, 32'h00000052);
    msg_ready = 0; idle(2);
    hs_vec.delete();
    @(negedge clk); irq[0] = 1; irq[1] = 1; irq[2] = 1; idle(12);
    check("R9 held while not ready", 32'(msg_vector), 32'h40);
    msg_ready = 1; idle(12);
    check("R10 three deliveries", 32'(hs_vec.size()), 3);
    if (hs_vec.size() == 3) begin
      check("R10 order first", 32'(hs_vec[0]), 32'h40);
      check("R10 order second", 32'(hs_vec[1]), 32'h41);
      check("R10 order third", 32'(hs_vec[2]), 32'h52);
    end
    irq = 4'b1000; idle(6);

    // R6 setting mask drops pending edge
    msg_ready = 0; base = hs_count;
    @(negedge clk); irq[0] = 0; idle(3); irq[0] = 1; irq[1] = 0; idle(3); irq[1] = 1; idle(6);
    wr_reg(8'h12, 32'h00010841); msg_ready = 1; idle(10);
    check("R6 masked pending dropped", 32'(hs_count - base), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule